// File: doc/BRIEF.md
# Pixel Serializer with Colour Palette

This block turns words fetched from video memory into a stream of colour values. Each memory word holds two 4-bit pixels. A word is captured once for every two pixel-clock enables. It is loaded into two shift groups at the same time. One group hands out pixels high nibble first, for an upright screen. The other hands them out low nibble first, for a screen turned round for the opposite player. A select input picks which group feeds the pixel path.

Each pixel indexes a 16-entry palette of 8-bit colours. Any 16 of 256 colours can be shown at once. The CPU may rewrite a palette entry at any time. While it writes, the palette address is taken from the CPU index instead of the pixel stream. The displayed colour for that pixel slot is then the value being written. The colour output is a register that updates only on the pixel-clock enable and is forced to zero during blanking.

Top module: `pixel_colour_serializer`

## Requirements
- R1: While reset is applied and after it is released, `colour` is 0, every palette entry holds 0, and the pixel phase is at a word-load slot.
- R2: With `flip` low, a word captured at a load slot shows as palette[word[7:4]] after the next `pix_en`, and then as palette[word[3:0]] after the `pix_en` after that.
- R3: With `flip` high, the order is reversed: palette[word[3:0]] shows first, then palette[word[7:4]].
- R4: `vram_word` is captured only on every second `pix_en`, starting with the first one after reset. Its value on the other `pix_en` has no effect on the output.
- R5: `colour` and all internal state hold their value in every cycle where `pix_en` is low, whatever the other inputs do.
- R6: A `pix_en` with `cpu_we` high stores `cpu_data` in palette entry `cpu_idx`. Later pixels with that index show the stored value.
- R7: In the `pix_en` cycle of a CPU write with `blank` low, `colour` becomes `cpu_data` in place of the pixel's own colour.
- R8: A `pix_en` with `blank` high sets `colour` to 0. This holds during a CPU write too, and that write is still stored.
- R9: `cpu_we` high while `pix_en` is low stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pix_en | input | 1 | Pixel-clock enable, one pixel per assertion |
| blank | input | 1 | Blanking interval, forces colour to 0 |
| flip | input | 1 | 1 selects the reversed-order shift group |
| vram_word | input | 8 | Two-pixel word from video memory |
| cpu_we | input | 1 | CPU palette write request |
| cpu_idx | input | 4 | Palette entry to write |
| cpu_data | input | 8 | Colour value to write |
| colour | output | 8 | Registered 8-bit colour |

## Verification
A wrong pixel phase shows up as swapped nibbles or a word taken from the wrong slot, at the first or second pixel enable after a load. A shift group with the wrong direction shows up when the two nibbles of a word have different palette colours. A corrupted palette entry stays hidden until a pixel with that index is shown. For that reason the bench fills all 16 entries with distinct values and then reads them back through the pixel path. A missing write bypass or blank override is visible in the very same pixel slot.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  // Geometry of the pixel path
  localparam int unsigned WORD_W       = 8;
  localparam int unsigned PIX_W        = 4;
  localparam int unsigned COL_W        = 8;
  localparam int unsigned PIX_PER_WORD = WORD_W / PIX_W;
  localparam int unsigned PAL_DEPTH    = 1 << PIX_W;
  localparam int unsigned PH_W         = (PIX_PER_WORD > 1) ? $clog2(PIX_PER_WORD) : 1;
  localparam int unsigned N_GROUPS     = 2;

  typedef enum logic {
    ORDER_NORMAL  = 1'b0,
    ORDER_REVERSE = 1'b1
  } shift_order_e;
endpackage

// File: rtl/pcs_reset_sync.sv
module pcs_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  // Assert asynchronously, release after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/pcs_pixel_timer.sv
module pcs_pixel_timer #(
  parameter int unsigned PIX_PER_WORD = 2,
  parameter int unsigned PH_W         = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pix_en,
  output logic load,
  output logic step
);
  logic [PH_W-1:0] phase_q, phase_d;
  logic            at_load;

  assign at_load = (phase_q == '0);

  always_comb begin
    phase_d = phase_q;
    if (pix_en) begin
      if (phase_q == PH_W'(PIX_PER_WORD - 1)) phase_d = '0;
      else                                     phase_d = phase_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  assign load = pix_en & at_load;
  assign step = pix_en & ~at_load;

  // Two consecutive load slots are impossible
  AST_LOAD_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !load); // R4

  // A load slot is always followed, at the next enable, by a shift slot
  AST_STEP_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (load && PIX_PER_WORD > 1) |=> (pix_en -> step) || !pix_en); // R4
endmodule

// File: rtl/pcs_nibble_shifter.sv
module pcs_nibble_shifter
  import pcs_pkg::*;
#(
  parameter int unsigned  WORD_W = 8,
  parameter int unsigned  PIX_W  = 4,
  parameter shift_order_e ORDER  = ORDER_NORMAL
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [WORD_W-1:0] word,
  output logic [PIX_W-1:0]  pixel
);
  logic [WORD_W-1:0] sh_q, sh_d;
  logic [WORD_W-1:0] shifted;

  generate
    if (ORDER == ORDER_NORMAL) begin : g_msb_first
      assign pixel   = sh_q[WORD_W-1 -: PIX_W];
      assign shifted = sh_q << PIX_W;
    end else begin : g_lsb_first
      assign pixel   = sh_q[PIX_W-1:0];
      assign shifted = sh_q >> PIX_W;
    end
  endgenerate

  always_comb begin
    sh_d = sh_q;
    if (load)      sh_d = word;
    else if (step) sh_d = shifted;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  // Without a load or shift slot the shifter is frozen
  AST_SHIFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(load || step) |=> $stable(sh_q)); // R5

  // A captured word is present in full right after its load slot
  AST_SHIFTER_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> sh_q == $past(word)); // R4
endmodule

// File: rtl/pcs_palette.sv
module pcs_palette #(
  parameter int unsigned PIX_W     = 4,
  parameter int unsigned COL_W     = 8,
  parameter int unsigned PAL_DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_en,
  input  logic             blank,
  input  logic [PIX_W-1:0] pix_idx,
  input  logic             cpu_we,
  input  logic [PIX_W-1:0] cpu_idx,
  input  logic [COL_W-1:0] cpu_data,
  output logic [COL_W-1:0] colour_q
);
  logic [PAL_DEPTH-1:0][COL_W-1:0] mem_q, mem_d;
  logic [PIX_W-1:0]                addr;
  logic [COL_W-1:0]                lookup;
  logic [COL_W-1:0]                colour_d;
  logic                            wr_fire;

  // Address selector: CPU index wins over pixel stream during a write
  assign addr    = cpu_we ? cpu_idx : pix_idx;
  assign wr_fire = pix_en & cpu_we;

  // Read path; a write shows its own data in the same slot
  always_comb begin
    if (cpu_we) lookup = cpu_data;
    else        lookup = mem_q[addr];
  end

  always_comb begin
    mem_d = mem_q;
    if (wr_fire) mem_d[addr] = cpu_data;
  end

  always_comb begin
    colour_d = colour_q;
    if (pix_en) colour_d = blank ? '0 : lookup;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q    <= '0;
      colour_q <= '0;
    end else begin
      mem_q    <= mem_d;
      colour_q <= colour_d;
    end
  end

  AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> $stable(mem_q)); // R9

  AST_WRITE_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> mem_q[$past(cpu_idx)] == $past(cpu_data)); // R6

  AST_WRITE_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !blank) |=> colour_q == $past(cpu_data)); // R7

  AST_BLANK_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && blank) |=> colour_q == '0); // R8

  AST_COLOUR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> $stable(colour_q)); // R5
endmodule

// File: rtl/pixel_colour_serializer.sv
module pixel_colour_serializer
  import pcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_en,
  input  logic              blank,
  input  logic              flip,
  input  logic [WORD_W-1:0] vram_word,
  input  logic              cpu_we,
  input  logic [PIX_W-1:0]  cpu_idx,
  input  logic [COL_W-1:0]  cpu_data,
  output logic [COL_W-1:0]  colour
);
  logic                 rst_n_sync;
  logic                 load;
  logic                 step;
  logic [PIX_W-1:0]     grp_pix [N_GROUPS];
  logic [PIX_W-1:0]     pix_sel;

  pcs_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  pcs_pixel_timer #(
    .PIX_PER_WORD (PIX_PER_WORD),
    .PH_W         (PH_W)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .pix_en (pix_en),
    .load   (load),
    .step   (step)
  );

  // Group 0 shifts high nibble first, group 1 low nibble first
  for (genvar g = 0; g < N_GROUPS; g++) begin : g_group
    pcs_nibble_shifter #(
      .WORD_W (WORD_W),
      .PIX_W  (PIX_W),
      .ORDER  ((g == 0) ? ORDER_NORMAL : ORDER_REVERSE)
    ) u_shift (
      .clk   (clk),
      .rst_n (rst_n_sync),
      .load  (load),
      .step  (step),
      .word  (vram_word),
      .pixel (grp_pix[g])
    );
  end

  // Orientation selector
  assign pix_sel = grp_pix[flip ? 1 : 0];

  pcs_palette #(
    .PIX_W     (PIX_W),
    .COL_W     (COL_W),
    .PAL_DEPTH (PAL_DEPTH)
  ) u_pal (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .pix_en   (pix_en),
    .blank    (blank),
    .pix_idx  (pix_sel),
    .cpu_we   (cpu_we),
    .cpu_idx  (cpu_idx),
    .cpu_data (cpu_data),
    .colour_q (colour)
  );

  AST_RESET_BLACK: assert property (@(posedge clk)
    !rst_n_sync |=> colour == '0); // R1
endmodule

// File: tb/test_pixel_colour_serializer.sv
module test_pixel_colour_serializer;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       pix_en, blank, flip, cpu_we;
  logic [7:0] vram_word, cpu_data;
  logic [3:0] cpu_idx;
  logic [7:0] colour;

  int n_vec = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  pixel_colour_serializer i_pixel_colour_serializer (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .blank(blank), .flip(flip),
    .vram_word(vram_word), .cpu_we(cpu_we), .cpu_idx(cpu_idx),
    .cpu_data(cpu_data), .colour(colour)
  );

  // {flip, word}
  localparam logic [8:0] VEC [8] = '{
    9'h0_12, 9'h1_12, 9'h0_AF, 9'h1_AF,
    9'h0_F0, 9'h1_3C, 9'h0_77, 9'h1_E9
  };

  function automatic logic [7:0] pal_val(input logic [3:0] i);
    return {i, ~i};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: colour=%02h expected %02h", req, act, exp);
    end
  endtask

  // One pixel enable followed by one idle cycle; sample afterwards
  task automatic step(input logic [7:0] w, input logic f, input logic b,
                      input logic we, input logic [3:0] idx, input logic [7:0] d);
    @(negedge clk);
    vram_word = w; flip = f; blank = b; cpu_we = we; cpu_idx = idx; cpu_data = d;
    pix_en = 1'b1;
    @(negedge clk);
    pix_en = 1'b0; cpu_we = 1'b0; vram_word = ~w;
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pix_en = 1'b0; blank = 1'b0; flip = 1'b0; cpu_we = 1'b0;
    vram_word = '0; cpu_data = '0; cpu_idx = '0;
    repeat (2) @(negedge clk);
    check("R1 during reset", colour, 8'h00);
    do_reset();
    check("R1 after reset", colour, 8'h00);

    // Palette cleared by reset: any pixel shows 0
    step(8'hA5, 1'b0, 1'b0, 1'b0, 4'h0, 8'h00);
    step(8'h00, 1'b0, 1'b0, 1'b0, 4'h0, 8'h00);
    check("R1 palette cleared", colour, 8'h00);
    step(8'h00, 1'b0, 1'b0, 1'b0, 4'h0, 8'h00);
    step(8'h00, 1'b0, 1'b0, 1'b0, 4'h0, 8'h00);

    // Fill palette; each write slot shows the written value
    for (int i = 0; i < 16; i++) begin
      step(8'h00, 1'b0, 1'b0, 1'b1, 4'(i), pal_val(4'(i)));
      check("R7 write bypass", colour, pal_val(4'(i)));
    end

    // Vector table: load slot, first pixel, second pixel, filler
    for (int k = 0; k < 8; k++) begin
      logic       f;
      logic [7:0] w;
      f = VEC[k][8];
      w = VEC[k][7:0];
      step(w, f, 1'b0, 1'b0, 4'h0, 8'h00);
      step(~w, f, 1'b0, 1'b0, 4'h0, 8'h00);  // R4: word here is ignored
      check(f ? "R3 first pixel" : "R2 first pixel", colour,
            pal_val(f ? w[3:0] : w[7:4]));
      step(8'h00, f, 1'b0, 1'b0, 4'h0, 8'h00);
      check(f ? "R3 second pixel" : "R2 second pixel", colour,
            pal_val(f ? w[7:4] : w[3:0]));
      step(8'h5A, f, 1'b0, 1'b0, 4'h0, 8'h00);  // R4: ignored slot
      check("R4 off-slot word ignored", colour, pal_val(4'h0));
    end

    // R5: no enable, inputs churn, colour holds
    step(8'h9C, 1'b0, 1'b0, 1'b0, 4'h0, 8'h00);
    check("R5 before idle", colour, pal_val(4'h0));
    repeat (5) begin
      @(negedge clk);
      vram_word = 8'hFF; blank = 1'b1; flip = 1'b1;
    end
    check("R5 hold without pix_en", colour, pal_val(4'h0));
    blank = 1'b0;
    step(8'h00, 1'b0, 1'b0, 1'b0, 4'h0, 8'h00);
    check("R5 word kept over idle", colour, pal_val(4'h9));

    // R8: blank during write gives 0 but write lands
    step(8'h37, 1'b0, 1'b1, 1'b1, 4'h3, 8'hC3);
    check("R8 blank over write", colour, 8'h00);
    step(8'h00, 1'b0, 1'b0, 1'b0, 4'h0, 8'h00);
    check("R6 stored under blank", colour, 8'hC3);
    step(8'h00, 1'b0, 1'b1, 1'b0, 4'h0, 8'h00);
    check("R8 blank forces 0", colour, 8'h00);
    step(8'h00, 1'b0, 1'b0, 1'b0, 4'h0, 8'h00);
    check("R8 blank released", colour, pal_val(4'h0));

    // R9: write request without pix_en is dropped
    @(negedge clk);
    cpu_we = 1'b1; cpu_idx = 4'h5; cpu_data = 8'hEE;
    @(negedge clk);
    cpu_we = 1'b0;
    step(8'h55, 1'b1, 1'b0, 1'b0, 4'h0, 8'h00);
    step(8'h00, 1'b1, 1'b0, 1'b0, 4'h0, 8'h00);
    check("R9 idle write dropped", colour, pal_val(4'h5));
    step(8'h00, 1'b1, 1'b0, 1'b0, 4'h0, 8'h00);
    check("R9 idle write dropped", colour, pal_val(4'h5));

    // R1: reset mid-run clears colour and palette
    do_reset();
    check("R1 reset mid-run", colour, 8'h00);
    step(8'h3C, 1'b0, 1'b0, 1'b0, 4'h0, 8'h00);
    step(8'h00, 1'b0, 1'b0, 1'b0, 4'h0, 8'h00);
    check("R1 palette cleared again", colour, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule